// File: doc/BRIEF.md
# DMA Interrupt Coalescing Unit

This block is the interrupt logic of one channel of a descriptor-driven DMA engine. The engine sends it a single-cycle pulse each time a packet finishes, a single-cycle error pulse, and a prescaled timer tick. From these it decides when to interrupt the processor. Interrupts are coalesced in two ways. A completion counter fires once every N packets. A delay timer is restarted by every packet and fires if traffic stops before the count is reached, so a short burst is not left unreported.

The bus decoder outside this block writes the threshold, delay and enable fields, and a write-one-to-clear mask for the pending bits. It reads back two assembled words. The status word carries the pending bits together with the live countdown and timer values. The control word echoes the stored fields. A single level interrupt output is high while any pending bit is set whose enable is also set.

Top module: `dma_irq_coalescer`

## Requirements
- R1: After reset the threshold is 1, the delay is 0, all enables are 0, the countdown is 1, the timer is 0, no bit is pending and `irq` is low.
- R2: A control write (`cfg_we`) stores threshold, delay and enables, and reloads the countdown from the written threshold in the same cycle.
- R3: Each completion pulse lowers the countdown by one. A completion that finds the countdown at 1 instead sets the count-pending bit and reloads the countdown from the threshold. A countdown of 0 wraps to 255.
- R4: A completion while the delay field is nonzero loads the timer with the delay, even if the timer is running. With a delay of 0 a completion leaves the timer alone.
- R5: While nonzero, the timer drops by one on each `tick_en`. The tick that takes it from 1 to 0 is the single expiry event: it sets the delay-pending bit and reloads the countdown from the threshold. A tick at 0, or a cycle without a tick, leaves the timer unchanged.
- R6: When an expiry and a completion meet in one cycle, the reload is applied first and the completion then counts against the reloaded value. A completion that restarts the timer in the cycle of its final tick cancels that expiry.
- R7: `err_pulse` sets the error-pending bit.
- R8: A `clr_we` cycle clears each pending bit whose `clr_mask` bit is 1 and leaves the others. A set event and a clear of the same bit in one cycle leave the bit set.
- R9: `irq` is high exactly when some pending bit has its enable set.
- R10: `status_word` carries the timer in bits 31:24, the countdown in 23:16, and the pending bits in 14:12 (count, delay and error, from bit 12 up). `control_word` carries the delay in 31:24, the threshold in 23:16 and the enables in 14:12. All other bits read 0. Enable and mask bits use the same order as the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmpl_pulse | input | 1 | One-cycle packet-finished event |
| tick_en | input | 1 | Prescaled timer step |
| err_pulse | input | 1 | One-cycle error event |
| cfg_we | input | 1 | Control write strobe |
| cfg_thresh | input | 8 | Threshold to store |
| cfg_delay | input | 8 | Delay to store, 0 disables the timer |
| cfg_enable | input | 3 | Enables to store, order as pending bits |
| clr_we | input | 1 | Status write strobe |
| clr_mask | input | 3 | Pending bits to clear |
| irq | output | 1 | Level interrupt |
| status_word | output | 32 | Live status readback |
| control_word | output | 32 | Stored control readback |

## Verification
The assertions assume that completion and error events arrive as one-cycle pulses, that a tick may land in any cycle (including one that also carries a completion), and that control and clear writes can coincide with any event. The stimulus exercises exactly that space. A pseudo-random sequence draws completions, ticks, errors, clears and occasional reconfigurations independently every cycle, across a sweep of every threshold from 0 to 4 and every delay from 0 to 3. Directed steps force the coincidences on purpose: a set meeting a clear, a restart meeting the final tick, and an expiry meeting a completion.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;

    localparam int REG_W   = 32;
    localparam int FLD_W   = 8;
    localparam int N_SRC   = 3;
    localparam int SRC_LSB = 12;
    localparam int TH_LSB  = 16;
    localparam int DLY_LSB = 24;

    localparam int SRC_CNT = 0;
    localparam int SRC_DLY = 1;
    localparam int SRC_ERR = 2;

    typedef logic [FLD_W-1:0] fld_t;
    typedef logic [N_SRC-1:0] src_t;

    typedef struct packed {
        fld_t dly;
        fld_t th;
        src_t en;
    } ctrl_t;

    localparam fld_t  FLD_ONE  = fld_t'(1);
    localparam ctrl_t CTRL_RST = '{dly: '0, th: FLD_ONE, en: '0};

    function automatic logic [REG_W-1:0] pack_word(fld_t hi, fld_t mid, src_t bits);
        logic [REG_W-1:0] w;
        w = '0;
        w[DLY_LSB +: FLD_W] = hi;
        w[TH_LSB  +: FLD_W] = mid;
        w[SRC_LSB +: N_SRC] = bits;
        return w;
    endfunction

endpackage

// File: rtl/coal_counter.sv
module coal_counter
    import irq_coal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic done_i,
    input  logic reload_i,
    input  fld_t th_i,
    output fld_t cnt_o,
    output logic hit_o
);

    fld_t cnt_q, base, cnt_d;

    always_comb begin
        base  = reload_i ? th_i : cnt_q;
        hit_o = done_i && (base == FLD_ONE);
        if (!done_i)
            cnt_d = base;
        else if (hit_o)
            cnt_d = th_i;
        else
            cnt_d = base - FLD_ONE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= FLD_ONE;
        else
            cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
        (done_i && !reload_i && cnt_q != FLD_ONE) |=> cnt_q == $past(cnt_q) - FLD_ONE);

    a_r3_reload_on_hit: assert property (@(posedge clk) disable iff (rst)
        hit_o |=> cnt_q == $past(th_i));

    a_r5_reload_idle: assert property (@(posedge clk) disable iff (rst)
        (reload_i && !done_i) |=> cnt_q == $past(th_i));

endmodule

// File: rtl/coal_delay_timer.sv
module coal_delay_timer
    import irq_coal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic done_i,
    input  logic tick_i,
    input  fld_t dly_i,
    output fld_t tmr_o,
    output logic expire_o
);

    fld_t tmr_q, tmr_d;
    logic restart;

    always_comb begin
        restart  = done_i && (dly_i != '0);
        expire_o = tick_i && (tmr_q == FLD_ONE) && !restart;
        if (restart)
            tmr_d = dly_i;
        else if (tick_i && tmr_q != '0)
            tmr_d = tmr_q - FLD_ONE;
        else
            tmr_d = tmr_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            tmr_q <= '0;
        else
            tmr_q <= tmr_d;
    end

    assign tmr_o = tmr_q;

    a_r4_restart: assert property (@(posedge clk) disable iff (rst)
        (done_i && dly_i != '0) |=> tmr_q == $past(dly_i));

    a_r5_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !done_i) |=> $stable(tmr_q));

    a_r5_expire_reaches_zero: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> tmr_q == '0);

    a_r6_no_expire_on_restart: assert property (@(posedge clk) disable iff (rst)
        (done_i && dly_i != '0) |-> !expire_o);

endmodule

// File: rtl/coal_pending.sv
module coal_pending
    import irq_coal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  src_t set_i,
    input  logic clr_we_i,
    input  src_t clr_i,
    output src_t pend_o
);

    src_t pend_q, clr_eff;

    always_comb clr_eff = clr_we_i ? clr_i : '0;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~clr_eff) | set_i;
    end

    assign pend_o = pend_q;

    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));

    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_we_i && set_i == '0) |=> pend_q == ($past(pend_q) & ~$past(clr_i)));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr_we_i && set_i == '0) |=> $stable(pend_q));

endmodule

// File: rtl/dma_irq_coalescer.sv
module dma_irq_coalescer
    import irq_coal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmpl_pulse,
    input  logic             tick_en,
    input  logic             err_pulse,
    input  logic             cfg_we,
    input  logic [FLD_W-1:0] cfg_thresh,
    input  logic [FLD_W-1:0] cfg_delay,
    input  logic [N_SRC-1:0] cfg_enable,
    input  logic             clr_we,
    input  logic [N_SRC-1:0] clr_mask,
    output logic             irq,
    output logic [REG_W-1:0] status_word,
    output logic [REG_W-1:0] control_word
);

    ctrl_t ctrl_q, ctrl_new, ctrl_eff;
    fld_t  cnt, tmr;
    logic  hit, expire;
    src_t  set_vec, pend;

    always_comb begin
        ctrl_new = '{dly: cfg_delay, th: cfg_thresh, en: cfg_enable};
        ctrl_eff = cfg_we ? ctrl_new : ctrl_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= CTRL_RST;
        else if (cfg_we)
            ctrl_q <= ctrl_new;
    end

    coal_counter u_counter (
        .clk      (clk),
        .rst      (rst),
        .done_i   (cmpl_pulse),
        .reload_i (cfg_we || expire),
        .th_i     (ctrl_eff.th),
        .cnt_o    (cnt),
        .hit_o    (hit)
    );

    coal_delay_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .done_i   (cmpl_pulse),
        .tick_i   (tick_en),
        .dly_i    (ctrl_eff.dly),
        .tmr_o    (tmr),
        .expire_o (expire)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[SRC_CNT] = hit;
        set_vec[SRC_DLY] = expire;
        set_vec[SRC_ERR] = err_pulse;
    end

    coal_pending u_pending (
        .clk      (clk),
        .rst      (rst),
        .set_i    (set_vec),
        .clr_we_i (clr_we),
        .clr_i    (clr_mask),
        .pend_o   (pend)
    );

    assign irq          = |(pend & ctrl_q.en);
    assign status_word  = pack_word(tmr, cnt, pend);
    assign control_word = pack_word(ctrl_q.dly, ctrl_q.th, ctrl_q.en);

    a_r2_cfg_reload: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cmpl_pulse) |=> status_word[TH_LSB +: FLD_W] == $past(cfg_thresh));

    a_r7_error_sets: assert property (@(posedge clk) disable iff (rst)
        err_pulse |=> status_word[SRC_LSB + SRC_ERR]);

endmodule

// File: tb/test_dma_irq_coalescer.sv
module test_dma_irq_coalescer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmpl_pulse, tick_en, err_pulse, cfg_we, clr_we;
    logic [7:0]  cfg_thresh, cfg_delay;
    logic [2:0]  cfg_enable, clr_mask;
    logic        irq;
    logic [31:0] status_word, control_word;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_th, m_dly, m_cnt, m_tmr;
    logic [2:0] m_en, m_pend;
    logic [31:0] lcg = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_coalescer i_dma_irq_coalescer (
        .clk(clk), .rst(rst), .cmpl_pulse(cmpl_pulse), .tick_en(tick_en),
        .err_pulse(err_pulse), .cfg_we(cfg_we), .cfg_thresh(cfg_thresh),
        .cfg_delay(cfg_delay), .cfg_enable(cfg_enable), .clr_we(clr_we),
        .clr_mask(clr_mask), .irq(irq), .status_word(status_word),
        .control_word(control_word)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [7:0] hi, input logic [7:0] mid, input logic [2:0] b);
        return {hi, mid, 1'b0, b, 12'h000};
    endfunction

    task automatic model_compare();
        chk("R3 R10 countdown", {24'h0, status_word[23:16]}, {24'h0, m_cnt});
        chk("R5 R10 timer", {24'h0, status_word[31:24]}, {24'h0, m_tmr});
        chk("R8 R10 pending", status_word, mk(m_tmr, m_cnt, m_pend));
        chk("R2 control", control_word, mk(m_dly, m_th, m_en));
        chk("R9 irq", {31'h0, irq}, {31'h0, |(m_pend & m_en)});
    endtask

    task automatic step(input logic d, input logic t, input logic e,
                        input logic cw, input logic [7:0] th, input logic [7:0] dl, input logic [2:0] en,
                        input logic sw, input logic [2:0] cm);
        logic [7:0] eth, edl, base, ncnt, ntmr;
        logic restart, expire, hit;
        cmpl_pulse = d; tick_en = t; err_pulse = e;
        cfg_we = cw; cfg_thresh = th; cfg_delay = dl; cfg_enable = en;
        clr_we = sw; clr_mask = cm;
        eth     = cw ? th : m_th;
        edl     = cw ? dl : m_dly;
        restart = d && (edl != 8'd0);
        expire  = t && (m_tmr == 8'd1) && !restart;
        base    = (cw || expire) ? eth : m_cnt;
        hit     = d && (base == 8'd1);
        ncnt    = !d ? base : (hit ? eth : base - 8'd1);
        ntmr    = restart ? edl : ((t && m_tmr != 8'd0) ? m_tmr - 8'd1 : m_tmr);
        @(posedge clk);
        m_pend = (m_pend & ~(sw ? cm : 3'b000)) | {e, expire, hit};
        m_cnt = ncnt; m_tmr = ntmr;
        if (cw) begin m_th = th; m_dly = dl; m_en = en; end
        #1;
        cmpl_pulse = 0; tick_en = 0; err_pulse = 0; cfg_we = 0; clr_we = 0;
        model_compare();
    endtask

    task automatic idle(input logic d, input logic t, input logic e);
        step(d, t, e, 1'b0, 8'h0, 8'h0, 3'b000, 1'b0, 3'b000);
    endtask

    task automatic cfg(input logic [7:0] th, input logic [7:0] dl, input logic [2:0] en);
        step(1'b0, 1'b0, 1'b0, 1'b1, th, dl, en, 1'b0, 3'b000);
    endtask

    task automatic clr(input logic d, input logic [2:0] cm);
        step(d, 1'b0, 1'b0, 1'b0, 8'h0, 8'h0, 3'b000, 1'b1, cm);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cmpl_pulse = 0; tick_en = 0; err_pulse = 0; cfg_we = 0; clr_we = 0;
        cfg_thresh = 0; cfg_delay = 0; cfg_enable = 0; clr_mask = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        m_th = 8'd1; m_dly = 8'd0; m_en = 3'b000; m_cnt = 8'd1; m_tmr = 8'd0; m_pend = 3'b000;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 status", status_word, 32'h0001_0000);
        chk("R1 control", control_word, 32'h0001_0000);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        idle(1, 0, 0);
        chk("R3 hit at threshold 1", status_word, 32'h0001_1000);
        chk("R9 masked", {31'h0, irq}, 32'h0);
        clr(0, 3'b001);
        chk("R8 clear", status_word, 32'h0001_0000);

        cfg(8'd3, 8'd0, 3'b001);
        chk("R2 control fields", control_word, 32'h0003_1000);
        chk("R2 countdown reload", status_word, 32'h0003_0000);
        idle(1, 0, 0); idle(1, 0, 0);
        chk("R3 count down", status_word, 32'h0001_0000);
        idle(1, 0, 0);
        chk("R3 third hit", status_word, 32'h0003_1000);
        chk("R9 irq raised", {31'h0, irq}, 32'h1);

        clr(0, 3'b001);
        idle(1, 0, 0); idle(1, 0, 0);
        clr(1, 3'b001);
        chk("R8 set wins", status_word, 32'h0003_1000);

        cfg(8'd2, 8'd5, 3'b010);
        chk("R9 other enable", {31'h0, irq}, 32'h0);
        clr(0, 3'b111);
        idle(1, 0, 0);
        chk("R4 load timer", status_word, 32'h0501_0000);
        idle(0, 1, 0); idle(0, 1, 0);
        chk("R5 ticks", status_word, 32'h0301_0000);
        idle(1, 0, 0);
        chk("R4 restart running", status_word, 32'h0502_1000);
        for (int i = 0; i < 5; i++) idle(0, 1, 0);
        chk("R5 expiry", status_word, 32'h0002_3000);
        chk("R9 delay irq", {31'h0, irq}, 32'h1);
        idle(0, 1, 0);
        chk("R5 tick at zero", status_word, 32'h0002_3000);
        idle(0, 0, 1);
        chk("R7 error bit", status_word, 32'h0002_7000);

        clr(0, 3'b111);
        idle(1, 0, 0);
        for (int i = 0; i < 4; i++) idle(0, 1, 0);
        idle(1, 1, 0);
        chk("R6 restart cancels expiry", status_word, 32'h0502_1000);
        cfg(8'd2, 8'd0, 3'b000);
        for (int i = 0; i < 4; i++) idle(0, 1, 0);
        chk("R4 zero delay keeps timer", status_word, 32'h0102_1000);
        idle(1, 1, 0);
        chk("R6 reload then count", status_word, 32'h0001_3000);
        cfg(8'd0, 8'd0, 3'b000);
        idle(1, 0, 0);
        chk("R3 wrap", status_word, 32'h00FF_3000);

        for (int th = 0; th < 5; th++) begin
            for (int dl = 0; dl < 4; dl++) begin
                do_reset();
                cfg(8'(th), 8'(dl), 3'b111);
                for (int n = 0; n < 48; n++) begin
                    lcg = lcg * 32'd1664525 + 32'd1013904223;
                    step(lcg[9:8] == 2'b00, lcg[12], lcg[16:13] == 4'h0,
                         lcg[21:17] == 5'h00, 8'(lcg[24:22] % 5), 8'(lcg[26:25]), lcg[29:27],
                         lcg[31:30] == 2'b00, lcg[4:2]);
                end
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule